// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block drives the control lines of several switchable power domains. Each domain owns bits in three 32-bit control registers: a gate register (1 = domain switched off), a clamp register (0 = isolation clamps active, 1 = clamps released) and a unit-reset register (0 = unit held in reset, 1 = released). All three registers can be read and written over a simple memory-mapped port. The registers drive the output lines directly.

Each domain also has an on-request and an off-request strobe. An accepted request makes a hardware sequencer walk that domain's fixed step order. Switching off closes the clamps, then asserts reset, then opens the power gate. Switching on closes the power gate, then releases reset, then opens the clamps. Each step is a read-modify-write that touches only the bits of the domain's mask. A programmable gap separates the steps, and a step whose mask is zero is skipped.

A separate reset-pulse strobe drops one selected reset line for a single cycle. While the sequencer runs, `busy_o` is high. `done_o` pulses for one cycle when a sequence finishes.

Top module: `pds_ctrl`

## Requirements
- R1: After reset the gate register reads 0x00000000, the clamp and unit-reset registers read 0xFFFFFFFF, and busy_o and done_o are low.
- R2: A write with bus_wr_i high stores all 32 bits of bus_wdata_i into the register selected by bus_addr_i: 0x10 for gate, 0x30 for unit-reset, 0x58 for clamp. bus_rdata_o returns that register in the same cycle. Any other address reads 0, and a write to it changes no register.
- R3: An off sequence applies three steps in order: clear the domain's clamp-mask bits, then clear its reset-mask bits, then set its gate-mask bits. Call k the clock edge that samples the request. Step j (counting from 0) is visible after edge k + j*(G+1), where G is step_gap_i, which is held constant while busy.
- R4: An on sequence applies three steps in order: clear the domain's gate-mask bits, then set its reset-mask bits, then set its clamp-mask bits. The timing is the same as in R3.
- R5: A step whose domain mask is zero is skipped. The following steps move up into its slot, so a sequence with n non-empty steps has no idle slot.
- R6: busy_o is high after edge k and stays high until edge k + n*(G+1). After that edge busy_o is low and done_o is high for exactly one cycle.
- R7: Sequencer steps change only the bits of the active domain's mask. Every other bit keeps its value, including values earlier written over the bus.
- R8: Requests sampled while busy_o is high are ignored. When idle, the lowest-indexed domain with any request wins. A domain that raises both strobes in the same cycle is switched off.
- R9: Bus writes are accepted while busy. If a bus write and a sequencer step hit the same register at the same edge, the step's mask bits take the sequencer value and all other bits take the bus data.
- R10: A pulse request with line_sel_i = i clears unit-reset bit i after edge k and sets it back to 1 after edge k+1, leaving the other bits unchanged. A pulse request sampled at edge k+1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| on_req_i | input | NDOM | Per-domain switch-on request |
| off_req_i | input | NDOM | Per-domain switch-off request |
| step_gap_i | input | GAP_W | Extra cycles between sequence steps |
| line_pulse_i | input | 1 | Single reset-line pulse request |
| line_sel_i | input | 5 | Index of the reset line to pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| gate_off_o | output | 32 | Gate register (1 = domain off) |
| clamp_n_o | output | 32 | Clamp register (0 = clamps active) |
| unit_rst_n_o | output | 32 | Unit-reset register (0 = held in reset) |

## Verification
A register write lands on the edge that samples it, one register stage. The first sequencer step lands on the same edge that samples the request. Step j lands j*(G+1) edges later, and the done pulse and the fall of busy come n*(G+1) edges after the request edge. The reset-line pulse clears its bit on the sampling edge and restores it on the next edge. The driver turns each of these into an absolute edge number, and the monitor compares each register snapshot a few nanoseconds after exactly that edge. An expectation that the monitor has passed without comparing counts as a failure.

// File: rtl/pds_pkg.sv
package pds_pkg;
    localparam int unsigned REG_W = 32;
    localparam logic [7:0] OFS_GATE  = 8'h10;
    localparam logic [7:0] OFS_URST  = 8'h30;
    localparam logic [7:0] OFS_CLAMP = 8'h58;

    typedef enum logic [1:0] {K_CLAMP, K_URST, K_GATE, K_NONE} step_kind_e;
    typedef enum logic {S_IDLE, S_RUN} seq_state_e;

    typedef struct packed {
        logic             valid;
        logic             turn_on;
        step_kind_e       kind;
        logic [REG_W-1:0] mask;
    } reg_op_t;
endpackage

// File: rtl/pds_arbiter.sv
module pds_arbiter #(
    parameter int unsigned NDOM  = 3,
    parameter int unsigned DOM_W = (NDOM > 1) ? $clog2(NDOM) : 1
) (
    input  logic [NDOM-1:0]  on_req_i,
    input  logic [NDOM-1:0]  off_req_i,
    output logic             hit_o,
    output logic [DOM_W-1:0] dom_o,
    output logic             turn_on_o
);
    always_comb begin
        hit_o     = 1'b0;
        dom_o     = '0;
        turn_on_o = 1'b0;
        for (int i = NDOM - 1; i >= 0; i--) begin
            if (on_req_i[i] || off_req_i[i]) begin
                hit_o     = 1'b1;
                dom_o     = DOM_W'(i);
                turn_on_o = !off_req_i[i];
            end
        end
    end
endmodule

// File: rtl/pds_seq.sv
module pds_seq
    import pds_pkg::*;
#(
    parameter int unsigned NDOM  = 3,
    parameter int unsigned GAP_W = 8,
    parameter int unsigned DOM_W = (NDOM > 1) ? $clog2(NDOM) : 1,
    parameter logic [NDOM-1:0][REG_W-1:0] GATE_MASK  = '0,
    parameter logic [NDOM-1:0][REG_W-1:0] CLAMP_MASK = '0,
    parameter logic [NDOM-1:0][REG_W-1:0] URST_MASK  = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hit_i,
    input  logic [DOM_W-1:0] dom_i,
    input  logic             turn_on_i,
    input  logic [GAP_W-1:0] step_gap_i,
    output reg_op_t          op_o,
    output logic             busy_o,
    output logic             done_o
);
    typedef struct packed {
        seq_state_e       st;
        logic [DOM_W-1:0] dom;
        logic             on;
        logic [1:0]       pos;
        logic [GAP_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    function automatic step_kind_e kind_at(logic on, logic [1:0] pos);
        case (pos)
            2'd0:    return on ? K_GATE : K_CLAMP;
            2'd1:    return K_URST;
            2'd2:    return on ? K_CLAMP : K_GATE;
            default: return K_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] mask_of(logic [DOM_W-1:0] dom, step_kind_e kind);
        case (kind)
            K_GATE:  return GATE_MASK[dom];
            K_CLAMP: return CLAMP_MASK[dom];
            K_URST:  return URST_MASK[dom];
            default: return '0;
        endcase
    endfunction

    function automatic logic [1:0] next_pos(logic [DOM_W-1:0] dom, logic on, logic [2:0] from);
        logic [1:0] found;
        found = 2'd3;
        for (int p = 2; p >= 0; p--) begin
            if (3'(p) >= from && mask_of(dom, kind_at(on, 2'(p))) != '0) found = 2'(p);
        end
        return found;
    endfunction

    logic [1:0] np;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        op_o     = '0;
        np       = 2'd3;
        case (s_q.st)
            S_IDLE: begin
                if (hit_i) begin
                    np = next_pos(dom_i, turn_on_i, 3'd0);
                    if (np == 2'd3) begin
                        s_d.done = 1'b1;
                    end else begin
                        op_o       = '{valid: 1'b1, turn_on: turn_on_i,
                                       kind: kind_at(turn_on_i, np),
                                       mask: mask_of(dom_i, kind_at(turn_on_i, np))};
                        s_d.st  = S_RUN;
                        s_d.dom = dom_i;
                        s_d.on  = turn_on_i;
                        s_d.pos = np;
                        s_d.cnt = step_gap_i;
                    end
                end
            end
            default: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    np = next_pos(s_q.dom, s_q.on, {1'b0, s_q.pos} + 3'd1);
                    if (np == 2'd3) begin
                        s_d.st   = S_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        op_o    = '{valid: 1'b1, turn_on: s_q.on,
                                    kind: kind_at(s_q.on, np),
                                    mask: mask_of(s_q.dom, kind_at(s_q.on, np))};
                        s_d.pos = np;
                        s_d.cnt = step_gap_i;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: S_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign busy_o = (s_q.st == S_RUN);
    assign done_o = s_q.done;

    assert_done_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);
    assert_done_not_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
    assert_ignore_when_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (!busy_o || ($stable(s_q.dom) && $stable(s_q.on))));
endmodule

// File: rtl/pds_regfile.sv
module pds_regfile
    import pds_pkg::*;
#(
    parameter int unsigned SEL_W = $clog2(REG_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_wr_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    input  reg_op_t          op_i,
    input  logic             pulse_i,
    input  logic [SEL_W-1:0] pulse_sel_i,
    output logic [REG_W-1:0] gate_o,
    output logic [REG_W-1:0] clamp_o,
    output logic [REG_W-1:0] urst_o
);
    typedef struct packed {
        logic [REG_W-1:0] gate;
        logic [REG_W-1:0] clamp;
        logic [REG_W-1:0] urst;
        logic             pend;
        logic [SEL_W-1:0] sel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_wr_i) begin
            case (bus_addr_i)
                OFS_GATE:  r_d.gate  = bus_wdata_i;
                OFS_CLAMP: r_d.clamp = bus_wdata_i;
                OFS_URST:  r_d.urst  = bus_wdata_i;
                default: ;
            endcase
        end
        if (op_i.valid) begin
            case (op_i.kind)
                K_GATE:  r_d.gate  = op_i.turn_on ? (r_d.gate & ~op_i.mask) : (r_d.gate | op_i.mask);
                K_CLAMP: r_d.clamp = op_i.turn_on ? (r_d.clamp | op_i.mask) : (r_d.clamp & ~op_i.mask);
                K_URST:  r_d.urst  = op_i.turn_on ? (r_d.urst | op_i.mask) : (r_d.urst & ~op_i.mask);
                default: ;
            endcase
        end
        if (r_q.pend) begin
            r_d.urst[r_q.sel] = 1'b1;
            r_d.pend          = 1'b0;
        end else if (pulse_i) begin
            r_d.urst[pulse_sel_i] = 1'b0;
            r_d.pend              = 1'b1;
            r_d.sel               = pulse_sel_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{gate: '0, clamp: '1, urst: '1, pend: 1'b0, sel: '0};
        else         r_q <= r_d;
    end

    always_comb begin
        case (bus_addr_i)
            OFS_GATE:  bus_rdata_o = r_q.gate;
            OFS_CLAMP: bus_rdata_o = r_q.clamp;
            OFS_URST:  bus_rdata_o = r_q.urst;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign gate_o  = r_q.gate;
    assign clamp_o = r_q.clamp;
    assign urst_o  = r_q.urst;

    logic [REG_W-1:0] sel_hot;
    assign sel_hot = REG_W'(1) << r_q.sel;

    assert_gate_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i.valid && op_i.kind == K_GATE && !op_i.turn_on)
        |=> ((gate_o & $past(op_i.mask)) == $past(op_i.mask)));
    assert_clamp_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i.valid && op_i.kind == K_CLAMP && op_i.turn_on)
        |=> ((clamp_o & $past(op_i.mask)) == $past(op_i.mask)));
    assert_other_bits_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i.valid && op_i.kind == K_GATE && !bus_wr_i)
        |=> (((gate_o ^ $past(gate_o)) & ~$past(op_i.mask)) == '0));
    assert_pulse_restores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.pend |=> ((urst_o & $past(sel_hot)) != '0));
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
    import pds_pkg::*;
#(
    parameter int unsigned NDOM  = 3,
    parameter int unsigned GAP_W = 8,
    parameter logic [NDOM-1:0][REG_W-1:0] GATE_MASK  = {32'h0000_0100, 32'h0000_0004, 32'h0000_0008},
    parameter logic [NDOM-1:0][REG_W-1:0] CLAMP_MASK = {32'h0000_0000, 32'h0000_0002, 32'h0000_0001},
    parameter logic [NDOM-1:0][REG_W-1:0] URST_MASK  = {32'h0004_0000, 32'h0000_0000, 32'h0001_0000}
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_wr_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    input  logic [NDOM-1:0]  on_req_i,
    input  logic [NDOM-1:0]  off_req_i,
    input  logic [GAP_W-1:0] step_gap_i,
    input  logic             line_pulse_i,
    input  logic [4:0]       line_sel_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [31:0]      gate_off_o,
    output logic [31:0]      clamp_n_o,
    output logic [31:0]      unit_rst_n_o
);
    localparam int unsigned DOM_W = (NDOM > 1) ? $clog2(NDOM) : 1;
    localparam int unsigned SEL_W = $clog2(REG_W);

    logic             hit;
    logic [DOM_W-1:0] dom;
    logic             turn_on;
    reg_op_t          op;

    pds_arbiter #(.NDOM(NDOM), .DOM_W(DOM_W)) u_arb (
        .on_req_i  (on_req_i),
        .off_req_i (off_req_i),
        .hit_o     (hit),
        .dom_o     (dom),
        .turn_on_o (turn_on)
    );

    pds_seq #(
        .NDOM(NDOM), .GAP_W(GAP_W), .DOM_W(DOM_W),
        .GATE_MASK(GATE_MASK), .CLAMP_MASK(CLAMP_MASK), .URST_MASK(URST_MASK)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hit_i      (hit),
        .dom_i      (dom),
        .turn_on_i  (turn_on),
        .step_gap_i (step_gap_i),
        .op_o       (op),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    pds_regfile #(.SEL_W(SEL_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .op_i        (op),
        .pulse_i     (line_pulse_i),
        .pulse_sel_i (line_sel_i),
        .gate_o      (gate_off_o),
        .clamp_o     (clamp_n_o),
        .urst_o      (unit_rst_n_o)
    );
endmodule

// File: tb/pds_ctrl_bench.sv
module pds_ctrl_bench;
    localparam int ND = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [ND-1:0] on_req = '0;
    logic [ND-1:0] off_req = '0;
    logic [7:0]  step_gap = '0;
    logic        line_pulse = 1'b0;
    logic [4:0]  line_sel = '0;
    logic        busy, done;
    logic [31:0] gate_off, clamp_n, unit_rst_n;

    pds_ctrl u_pds_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .on_req_i(on_req), .off_req_i(off_req), .step_gap_i(step_gap),
        .line_pulse_i(line_pulse), .line_sel_i(line_sel),
        .busy_o(busy), .done_o(done),
        .gate_off_o(gate_off), .clamp_n_o(clamp_n), .unit_rst_n_o(unit_rst_n)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        int          cyc;
        logic [31:0] g;
        logic [31:0] c;
        logic [31:0] r;
        logic        b;
        logic        d;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    logic [31:0] m_g = '0, m_c = '1, m_r = '1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] dmask(int dom, int kind); // kind 0 clamp, 1 reset, 2 gate
        case (dom)
            0: return (kind == 0) ? 32'h1 : (kind == 1) ? 32'h0001_0000 : 32'h8;
            1: return (kind == 0) ? 32'h2 : (kind == 1) ? 32'h0 : 32'h4;
            default: return (kind == 0) ? 32'h0 : (kind == 1) ? 32'h0004_0000 : 32'h100;
        endcase
    endfunction

    task automatic snap(input int c, input string tag, input logic b, input logic d);
        exp_q.push_back('{cyc: c, g: m_g, c: m_c, r: m_r, b: b, d: d});
        tag_q.push_back(tag);
    endtask

    // monitor: compare a few ns after each rising edge
    always @(posedge clk) begin
        #3;
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            checks++;
            if (exp_q[0].cyc < cyc) begin
                fails++;
                $display("FAIL %s missed expectation for edge %0d (now %0d)", tag_q[0], exp_q[0].cyc, cyc);
            end else if (gate_off !== exp_q[0].g || clamp_n !== exp_q[0].c ||
                         unit_rst_n !== exp_q[0].r || busy !== exp_q[0].b || done !== exp_q[0].d) begin
                fails++;
                $display("FAIL %s edge %0d actual g=%h c=%h r=%h b=%b d=%b expected g=%h c=%h r=%h b=%b d=%b",
                         tag_q[0], cyc, gate_off, clamp_n, unit_rst_n, busy, done,
                         exp_q[0].g, exp_q[0].c, exp_q[0].r, exp_q[0].b, exp_q[0].d);
            end
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic read_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s read %h actual %h expected %h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] v, input string tag);
        int k;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        k = cyc + 1;
        case (a)
            8'h10: m_g = v;
            8'h58: m_c = v;
            8'h30: m_r = v;
            default: ;
        endcase
        snap(k, tag, 1'b0, 1'b0);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run_req(input logic [ND-1:0] on_v, input logic [ND-1:0] off_v, input int dom,
                           input bit on, input int gap, input bit noise, input string tag);
        int k, j, kind;
        logic [31:0] m;
        @(negedge clk);
        step_gap = 8'(gap); on_req = on_v; off_req = off_v;
        k = cyc + 1; j = 0;
        for (int p = 0; p < 3; p++) begin
            kind = on ? (2 - p) : p;
            m = dmask(dom, kind);
            if (m != 0) begin
                case (kind)
                    0: m_c = on ? (m_c | m) : (m_c & ~m);
                    1: m_r = on ? (m_r | m) : (m_r & ~m);
                    default: m_g = on ? (m_g & ~m) : (m_g | m);
                endcase
                snap(k + j * (gap + 1), tag, 1'b1, 1'b0);
                j++;
            end
        end
        snap(k + j * (gap + 1), tag, 1'b0, 1'b1);
        snap(k + j * (gap + 1) + 1, tag, 1'b0, 1'b0);
        @(negedge clk);
        on_req = '0; off_req = '0;
        if (noise) begin
            on_req = '1; off_req = '1; // sampled while busy: R8 ignore
            @(negedge clk);
            on_req = '0; off_req = '0;
        end
        while (cyc < k + j * (gap + 1) + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_chk(8'h10, 32'h0, "R1");
        read_chk(8'h58, 32'hFFFF_FFFF, "R1");
        read_chk(8'h30, 32'hFFFF_FFFF, "R1");
        snap(cyc + 1, "R1", 1'b0, 1'b0);
        // R2 register map
        read_chk(8'h00, 32'h0, "R2");
        bus_write(8'h10, 32'h0000_0040, "R2");
        read_chk(8'h10, 32'h0000_0040, "R2");
        bus_write(8'h58, 32'hFFFF_FF7F, "R2");
        read_chk(8'h58, 32'hFFFF_FF7F, "R2");
        bus_write(8'h30, 32'hFFFF_FFFE, "R2");
        read_chk(8'h30, 32'hFFFF_FFFE, "R2");
        bus_write(8'h20, 32'hDEAD_BEEF, "R2");
        read_chk(8'h20, 32'h0, "R2");
        read_chk(8'h10, 32'h0000_0040, "R2");
        // R3 off order with gap, R7 other bits kept, R8 busy ignore, R6 busy/done
        run_req(3'b000, 3'b001, 0, 1'b0, 2, 1'b1, "R3");
        // R4 on order
        run_req(3'b001, 3'b000, 0, 1'b1, 1, 1'b0, "R4");
        // R5 skipped steps (domain 1 no reset step, domain 2 no clamp step)
        run_req(3'b000, 3'b010, 1, 1'b0, 0, 1'b0, "R5");
        run_req(3'b000, 3'b100, 2, 1'b0, 1, 1'b0, "R5");
        run_req(3'b100, 3'b000, 2, 1'b1, 0, 1'b0, "R5");
        run_req(3'b010, 3'b000, 1, 1'b1, 2, 1'b0, "R6");
        // R8 lowest index wins; off beats on for one domain
        run_req(3'b010, 3'b100, 1, 1'b1, 0, 1'b0, "R8");
        run_req(3'b001, 3'b001, 0, 1'b0, 0, 1'b0, "R8");
        run_req(3'b001, 3'b000, 0, 1'b1, 0, 1'b0, "R7");
        read_chk(8'h10, 32'h0000_0040, "R7");
        // R9 bus writes while busy, same-edge conflict on gate register
        begin
            int k;
            @(negedge clk);
            step_gap = 8'd1; off_req = 3'b010;
            k = cyc + 1;
            m_c = m_c & ~32'h2;
            snap(k, "R9", 1'b1, 1'b0);
            @(negedge clk);
            off_req = '0;
            bus_wr = 1'b1; bus_addr = 8'h58; bus_wdata = 32'h0000_00F2;
            m_c = 32'h0000_00F2;
            snap(k + 1, "R9", 1'b1, 1'b0);
            @(negedge clk);
            bus_addr = 8'h10; bus_wdata = 32'h0000_0011;
            m_g = 32'h0000_0015;
            snap(k + 2, "R9", 1'b1, 1'b0);
            @(negedge clk);
            bus_wr = 1'b0;
            snap(k + 4, "R9", 1'b0, 1'b1);
            while (cyc < k + 6) @(negedge clk);
        end
        // R10 single-line reset pulse; request during pending ignored
        begin
            int k;
            @(negedge clk);
            line_pulse = 1'b1; line_sel = 5'd5;
            k = cyc + 1;
            m_r = m_r & ~32'h20;
            snap(k, "R10", 1'b0, 1'b0);
            @(negedge clk);
            line_sel = 5'd7;
            m_r = m_r | 32'h20;
            snap(k + 1, "R10", 1'b0, 1'b0);
            @(negedge clk);
            line_pulse = 1'b0;
            snap(k + 2, "R10", 1'b0, 1'b0);
            repeat (3) @(negedge clk);
        end
        read_chk(8'h30, m_r, "R10");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL %s %0d expectations left actual 0 expected 0", tag_q[0], exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule